// File: doc/BRIEF.md
# Modem Line Control and Status Registers

This block holds the modem handshake side of one serial channel, as the CPU sees it through a small register bus. The control register drives the active-low DTR and RTS pins. It also holds two general-purpose bits, named OUT1 and OUT2, and a loopback enable. The status register shows the present level of the four modem inputs: clear-to-send, data-set-ready, ring indicator and carrier detect. Next to those levels it keeps four sticky change flags.

Each change flag records an event until the CPU reads the status register. A read returns the value from before the read and clears the flags in the same cycle. An event that arrives in that cycle is still kept. The block raises a modem-status interrupt request when the flags are non-zero and the enable input is set. It tags the request with priority level 4. OUT2 gates the request onto the external interrupt line.

In loopback mode the control bits replace the external inputs, and the DTR and RTS pins are held inactive. This lets software test the channel without a modem attached.

Top module: `mdm_ctrl_status`

## Requirements
- R1: After reset, the control register reads 0x00, dtr_n and rts_n are high, every change flag reads 0 and irq_req, irq_ext and irq_prio are 0.
- R2: Outside loopback, control bit 0 set to 1 drives dtr_n low, and bit 1 set to 1 drives rts_n low. A 0 in either bit drives its pin high.
- R3: Control register bits 7..5 always read 0. Bits 4..0 read back as written (sel_status=0).
- R4: Status bits 7..4 show DCD, RI, DSR and CTS in that order. Each bit is 1 when its pin is low, and it follows a pin change two clock edges later. Writes with sel_status=1 have no effect.
- R5: Status bit 0 (CTS), bit 1 (DSR) and bit 3 (DCD) become 1 on a change of their input in either direction. They stay 1 until the status register is read.
- R6: Status bit 2 becomes 1 only when ri_n goes from low to high. A high-to-low change on ri_n leaves it at 0.
- R7: A status read (rd_en=1, sel_status=1) returns the value held before that edge. After the edge, bits 3..0 are 0.
- R8: An input event detected in the same cycle as a status read leaves its change flag set after the read.
- R9: irq_req is 1 exactly when msi_en is 1 and any of status bits 3..0 is 1. irq_prio is 4 while irq_req is 1 and 0 otherwise.
- R10: irq_ext equals irq_req ANDed with control bit 3 (OUT2). Control bit 2 (OUT1) has no effect on any pin.
- R11: With control bit 4 set, status shows CTS=bit 1, DSR=bit 0, RI=bit 2 and DCD=bit 3. The external modem inputs are ignored, and dtr_n and rts_n are held high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_status | input | 1 | Register select: 0 control, 1 status |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; clears change flags when the status register is selected |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register |
| msi_en | input | 1 | Modem-status interrupt enable |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring indicator pin, active low |
| dcd_n | input | 1 | Carrier-detect pin, active low |
| dtr_n | output | 1 | Data-terminal-ready pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| irq_req | output | 1 | Modem-status interrupt request |
| irq_ext | output | 1 | Interrupt request gated by OUT2 |
| irq_prio | output | 3 | Priority tag of the pending request |

## Verification
The assertions assume that the bus strobes are clean single-cycle pulses relative to clk, and that wr_en and rd_en are never high together. They place no limit on how often the modem pins may toggle. The pins are asynchronous and reach the checked state only through the synchronizer.

The stimulus changes pins only at falling clock edges and waits for the synchronizer latency before reading. The exception is one deliberate case in which the read strobe is placed in the exact cycle an event is detected.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
    localparam int DATA_W   = 8;
    localparam int N_LINES  = 4;
    localparam int CTRL_W   = 5;

    // control bit positions (software visible)
    localparam int C_DTR  = 0;
    localparam int C_RTS  = 1;
    localparam int C_OUT1 = 2;
    localparam int C_OUT2 = 3;
    localparam int C_LOOP = 4;

    // line index inside the 4-bit level / delta vectors
    localparam int L_CTS = 0;
    localparam int L_DSR = 1;
    localparam int L_RI  = 2;
    localparam int L_DCD = 3;

    localparam logic [DATA_W-1:0] CTRL_MASK = DATA_W'((1 << CTRL_W) - 1);
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stg_q [STAGES];
    logic [WIDTH-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= RST_VAL;
                else        stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign sync_out = stg_q[STAGES-1];
endmodule

// File: rtl/mdm_ctrl_reg.sv
module mdm_ctrl_reg
    import mdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl,
    output logic              dtr_n,
    output logic              rts_n
);
    typedef struct packed {
        logic [DATA_W-1:0] value;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_ctrl) st_d.value = wdata & CTRL_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl = st_q.value;

    // in loopback the handshake pins are parked inactive
    always_comb begin
        if (st_q.value[C_LOOP]) begin
            dtr_n = 1'b1;
            rts_n = 1'b1;
        end else begin
            dtr_n = ~st_q.value[C_DTR];
            rts_n = ~st_q.value[C_RTS];
        end
    end
endmodule

// File: rtl/mdm_status.sv
module mdm_status
    import mdm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] ext_pin_n,
    input  logic [DATA_W-1:0]  ctrl,
    input  logic               rd_clear,
    output logic [DATA_W-1:0]  status,
    output logic [N_LINES-1:0] delta,
    output logic [N_LINES-1:0] evt
);
    typedef struct packed {
        logic [N_LINES-1:0] prev;
        logic [N_LINES-1:0] delta;
    } stat_state_t;

    stat_state_t st_d, st_q;
    logic [N_LINES-1:0] act;
    logic [N_LINES-1:0] loop_act;

    always_comb begin
        loop_act        = '0;
        loop_act[L_CTS] = ctrl[C_RTS];
        loop_act[L_DSR] = ctrl[C_DTR];
        loop_act[L_RI]  = ctrl[C_OUT1];
        loop_act[L_DCD] = ctrl[C_OUT2];
        act = ctrl[C_LOOP] ? loop_act : ~ext_pin_n;
    end

    always_comb begin
        evt        = act ^ st_q.prev;
        // ring flag only on the trailing edge (active -> inactive)
        evt[L_RI]  = st_q.prev[L_RI] & ~act[L_RI];
        st_d.prev  = act;
        st_d.delta = (rd_clear ? '0 : st_q.delta) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign delta  = st_q.delta;
    assign status = {act, st_q.delta};
endmodule

// File: rtl/mdm_ctrl_status.sv
module mdm_ctrl_status
    import mdm_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PRIO_W      = 3,
    parameter int PRIO_LEVEL  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_status,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              msi_en,
    input  logic              cts_n,
    input  logic              dsr_n,
    input  logic              ri_n,
    input  logic              dcd_n,
    output logic              dtr_n,
    output logic              rts_n,
    output logic              irq_req,
    output logic              irq_ext,
    output logic [PRIO_W-1:0] irq_prio
);
    logic [DATA_W-1:0]  ctrl_bits;
    logic [DATA_W-1:0]  status_bits;
    logic [N_LINES-1:0] delta_bits;
    logic [N_LINES-1:0] evt_bits;
    logic [N_LINES-1:0] pins_raw;
    logic [N_LINES-1:0] pins_sync;

    always_comb begin
        pins_raw        = '1;
        pins_raw[L_CTS] = cts_n;
        pins_raw[L_DSR] = dsr_n;
        pins_raw[L_RI]  = ri_n;
        pins_raw[L_DCD] = dcd_n;
    end

    mdm_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pins_raw), .sync_out(pins_sync)
    );

    mdm_ctrl_reg u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_en & ~sel_status), .wdata(wdata),
        .ctrl(ctrl_bits), .dtr_n(dtr_n), .rts_n(rts_n)
    );

    mdm_status u_stat (
        .clk(clk), .rst_n(rst_n), .ext_pin_n(pins_sync), .ctrl(ctrl_bits),
        .rd_clear(rd_en & sel_status), .status(status_bits),
        .delta(delta_bits), .evt(evt_bits)
    );

    always_comb begin
        rdata    = sel_status ? status_bits : ctrl_bits;
        irq_req  = msi_en & (|delta_bits);
        irq_ext  = irq_req & ctrl_bits[C_OUT2];
        irq_prio = irq_req ? PRIO_W'(PRIO_LEVEL) : '0;
    end
endmodule

// File: rtl/mdm_ctrl_status_chk.sv
module mdm_ctrl_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sel_status,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       dtr_n,
    input logic       rts_n,
    input logic       irq_req,
    input logic       irq_ext,
    input logic [2:0] irq_prio,
    input logic [7:0] ctrl_bits,
    input logic [3:0] delta_bits,
    input logic [3:0] evt_bits
);
    a_r2_pin_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sel_status && !wdata[4]) |=>
            (dtr_n == !$past(wdata[0])) && (rts_n == !$past(wdata[1])));

    a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_status |-> (rdata[7:5] == 3'b000));

    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (|delta_bits && !(rd_en && sel_status)) |=>
            ((delta_bits & $past(delta_bits)) == $past(delta_bits)));

    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel_status && !(|evt_bits)) |=> (delta_bits == 4'b0000));

    a_r8_no_lost_event: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_bits) |=> ((delta_bits & $past(evt_bits)) == $past(evt_bits)));

    a_r9_prio_tag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_prio == 3'd4));

    a_r10_ext_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ext |-> (irq_req && ctrl_bits[3]));

    a_r11_loop_parked: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_bits[4] |-> (dtr_n && rts_n));
endmodule

bind mdm_ctrl_status mdm_ctrl_status_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sel_status(sel_status), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .dtr_n(dtr_n), .rts_n(rts_n),
    .irq_req(irq_req), .irq_ext(irq_ext), .irq_prio(irq_prio),
    .ctrl_bits(ctrl_bits), .delta_bits(delta_bits), .evt_bits(evt_bits)
);

// File: tb/tb_mdm_ctrl_status.sv
module tb_mdm_ctrl_status;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_status = 1'b0, wr_en = 1'b0, rd_en = 1'b0, msi_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
    logic       dtr_n, rts_n, irq_req, irq_ext;
    logic [2:0] irq_prio;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        string      req;
        logic [7:0] val;
    } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    mdm_ctrl_status dut (
        .clk(clk), .rst_n(rst_n), .sel_status(sel_status), .wr_en(wr_en),
        .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .msi_en(msi_en),
        .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n),
        .dtr_n(dtr_n), .rts_n(rts_n), .irq_req(irq_req), .irq_ext(irq_ext),
        .irq_prio(irq_prio)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops scoreboard when a read strobe is active
    always begin
        @(negedge clk);
        #1;
        if (rd_en) begin
            if (sb_q.size() == 0) chk("scoreboard-empty", 8'h01, 8'h00);
            else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(e.req, rdata, e.val);
            end
        end
    end

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        sel_status = sel; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic sel, input logic [7:0] exp, input string req);
        @(negedge clk);
        sb_q.push_back('{req, exp});
        sel_status = sel; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    initial begin
        #400000;
        chk("watchdog", 8'h01, 8'h00);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle(2);
        // R1 reset state
        chk("R1 dtr_n", {7'b0, dtr_n}, 8'h01);
        chk("R1 rts_n", {7'b0, rts_n}, 8'h01);
        chk("R1 irq", {irq_req, irq_ext, 3'b0, irq_prio}, 8'h00);
        rd(1'b0, 8'h00, "R1 ctrl");
        rd(1'b1, 8'h00, "R1 status");
        // R2 R3
        wr(1'b0, 8'hE3);
        rd(1'b0, 8'h03, "R3 upper bits zero");
        settle(1);
        chk("R2 dtr_n low", {7'b0, dtr_n}, 8'h00);
        chk("R2 rts_n low", {7'b0, rts_n}, 8'h00);
        wr(1'b0, 8'h02);
        settle(1);
        chk("R2 dtr_n high", {7'b0, dtr_n}, 8'h01);
        // R10 OUT1 no effect
        wr(1'b0, 8'h07);
        settle(1);
        chk("R10 out1 pins", {6'b0, dtr_n, rts_n}, 8'h00);
        rd(1'b0, 8'h07, "R3 readback");
        // R4 R5 R7 CTS both directions
        @(negedge clk); cts_n = 1'b0;
        settle(4);
        rd(1'b1, 8'h11, "R5 cts fall");
        rd(1'b1, 8'h10, "R7 cleared");
        @(negedge clk); cts_n = 1'b1;
        settle(4);
        rd(1'b1, 8'h01, "R5 cts rise");
        rd(1'b1, 8'h00, "R7 cleared");
        // R6 ring trailing edge only
        @(negedge clk); ri_n = 1'b0;
        settle(4);
        rd(1'b1, 8'h40, "R6 no flag on fall");
        @(negedge clk); ri_n = 1'b1;
        settle(4);
        rd(1'b1, 8'h04, "R6 flag on rise");
        rd(1'b1, 8'h00, "R7 cleared");
        // R4 R5 DSR and DCD
        @(negedge clk); dsr_n = 1'b0;
        settle(4);
        rd(1'b1, 8'h22, "R5 dsr");
        @(negedge clk); dcd_n = 1'b0;
        settle(4);
        rd(1'b1, 8'hA8, "R5 dcd");
        rd(1'b1, 8'hA0, "R4 levels");
        // R4 status write ignored
        wr(1'b1, 8'hFF);
        rd(1'b1, 8'hA0, "R4 status write ignored");
        rd(1'b0, 8'h07, "R4 ctrl untouched");
        // R9 R10
        msi_en = 1'b1;
        settle(1);
        chk("R9 no request", {irq_req, 4'b0, irq_prio}, 8'h00);
        @(negedge clk); dcd_n = 1'b1;
        settle(4);
        chk("R9 request", {irq_req, 4'b0, irq_prio}, 8'h84);
        chk("R10 gated off", {7'b0, irq_ext}, 8'h00);
        wr(1'b0, 8'h0F);
        settle(1);
        chk("R10 gated on", {7'b0, irq_ext}, 8'h01);
        rd(1'b1, 8'h28, "R9 status");
        settle(1);
        chk("R9 cleared", {irq_req, 4'b0, irq_prio}, 8'h00);
        // R8 event in the read cycle
        @(negedge clk); cts_n = 1'b0;
        @(negedge clk);
        rd(1'b1, 8'h30, "R8 read before update");
        rd(1'b1, 8'h31, "R8 event kept");
        rd(1'b1, 8'h30, "R7 cleared");
        // R11 loopback
        wr(1'b0, 8'h1B);
        settle(1);
        chk("R11 pins parked", {6'b0, dtr_n, rts_n}, 8'h03);
        settle(3);
        rd(1'b1, 8'hB8, "R11 loop status");
        @(negedge clk); cts_n = 1'b1; dsr_n = 1'b1; ri_n = 1'b0;
        settle(4);
        rd(1'b1, 8'hB0, "R11 external ignored");
        wr(1'b0, 8'h1F);
        settle(3);
        wr(1'b0, 8'h1B);
        settle(3);
        rd(1'b1, 8'hB4, "R11 R6 loop ring edge");
        wr(1'b0, 8'h00);
        settle(3);
        rd(1'b1, 8'h4B, "R11 loop exit");
        settle(2);
        chk("scoreboard drained", 8'(sb_q.size()), 8'h00);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule